// File: doc/BRIEF.md
# Cache Maintenance Command Engine

This block owns the tag and state storage of a small two-way set-associative cache and carries out maintenance on it. Every entry holds a tag, a valid flag and a dirty (modified) flag. The engine takes one command at a time. A command names a scope: a single line found by physical address, a byte range, the whole cache, or an enable change. It also names an operation: search, invalidate, push or clear. The three maintenance operations update the flags in different ways. Push and clear can write back a line that is both valid and dirty, and they use a request and acknowledge handshake for this. The data RAM and the bus master sit outside the block. The engine only names the way, set and stored tag of each line that has to be written back.

Lines are 16 bytes and each way has 256 sets. An address lookup compares the tag in both ways of the indexed set. A byte range is walked line by line from the aligned start address up to the line that holds its last byte. A range of 4096 bytes or more, which is half the total capacity, becomes a whole-cache sweep. An enable change first sweeps the whole cache with invalidate and only then updates the cache-enable and write-buffer-enable outputs. A separate fill port installs lines. It stands in for the allocation path of the cache.

Top module: `cache_maint_engine`

## Requirements
- R1: A line command ignores the low four address bits. Set index = addr[11:4], tag = addr[31:12].
- R2: Invalidate (op code 1) clears both the valid flag and the dirty flag of the target entry and never requests a write-back.
- R3: Push (op code 2) requests a write-back only for a valid, dirty entry and then clears only its dirty flag, so the line stays valid. Other entries keep their flags.
- R4: Clear (op code 3) requests a write-back for a valid, dirty entry and then leaves it invalid and clean. A clean valid entry is invalidated with no write-back.
- R5: A line command compares the tag in both ways of the indexed set and acts on the way that matches. When no way matches, it changes no state and requests no write-back.
- R6: Search (op code 0) with line scope (scope code 0) pulses `srch_done` and reports hit, way and dirty flag. It changes no state.
- R7: A write-back request holds `wb_req` together with its way, set and tag until `wb_ack` is sampled high. The entry's flags change on that same edge.
- R8: A whole-cache sweep (scope code 1) visits sets 0 to 255 in ascending order, with way 0 before way 1 in each set. It takes one cycle per entry, 512 busy cycles in all, when there are no write-backs.
- R9: A range command (scope code 2) covers the lines from addr[31:4] up to the line of byte addr+len-1. With len >= 4096 it performs a whole-cache sweep instead.
- R10: An enable command (scope code 3) invalidates the whole cache without write-backs. It then loads `cache_en` and `wbuf_en` from `cmd_cache_on` and `cmd_wbuf_on` in the cycle in which busy falls.
- R11: A command presented while busy is ignored and sets `err_busy`. The flag stays set until reset.
- R12: A fill installs a valid entry with the given dirty flag into the given way, at the set and tag taken from `fill_addr`. A fill presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_scope | input | 2 | 0 line, 1 whole cache, 2 range, 3 enable change |
| cmd_op | input | 2 | 0 search, 1 invalidate, 2 push, 3 clear |
| cmd_addr | input | 32 | Physical address (line or range start) |
| cmd_len | input | 16 | Range length in bytes |
| cmd_cache_on | input | 1 | New cache-enable value for an enable command |
| cmd_wbuf_on | input | 1 | New write-buffer-enable value for an enable command |
| fill_en | input | 1 | Install a line |
| fill_way | input | 1 | Way to install into |
| fill_addr | input | 32 | Address of the installed line |
| fill_dirty | input | 1 | Dirty flag of the installed line |
| wb_ack | input | 1 | Write-back acknowledge |
| wb_req | output | 1 | Write-back request |
| wb_way | output | 1 | Way of the line to write back |
| wb_set | output | 8 | Set of the line to write back |
| wb_tag | output | 20 | Stored tag of the line to write back |
| busy | output | 1 | Command in progress |
| err_busy | output | 1 | Sticky flag for a command seen while busy |
| cache_en | output | 1 | Cache enable |
| wbuf_en | output | 1 | Write-buffer enable |
| srch_done | output | 1 | One-cycle pulse when a search result is ready |
| srch_hit | output | 1 | Search hit |
| srch_way | output | 1 | Way that hit |
| srch_dirty | output | 1 | Dirty flag of the line that hit |

## Verification
The bench puts the same set index in both ways with different tags and uses unaligned addresses. A lookup that checked one way only, or that used the low address bits, would then report the wrong line. It also pushes a clean line and clears a clean line. A design that mixed up the flag rules would emit spurious write-backs, or would leave lines valid or invalid when they should not be. Write-back order is scored against a queue across sweeps with entries in both ways. A sweep that went way 1 before way 0, or skipped the last set, would show up as a miscompare or an exact busy count other than 512. The range tests cover the line that holds the last byte, and a length of 4095 set against a length of 4096. An off-by-one in the half-size threshold would then write back a line outside the range. Commands and fills issued during a sweep check that they are dropped and that the error flag latches.

// File: rtl/cme_pkg.sv
package cme_pkg;

  typedef enum logic [1:0] {
    OP_SEARCH = 2'd0,
    OP_INVAL  = 2'd1,
    OP_PUSH   = 2'd2,
    OP_CLEAR  = 2'd3
  } cme_op_e;

  typedef enum logic [1:0] {
    SC_LINE   = 2'd0,
    SC_ALL    = 2'd1,
    SC_RANGE  = 2'd2,
    SC_ENABLE = 2'd3
  } cme_scope_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2
  } cme_state_e;

  typedef struct packed {
    logic valid;
    logic dirty;
  } cme_flags_t;

  // Flag update applied to one entry once any write-back it needed is done.
  function automatic cme_flags_t cme_next_flags(cme_op_e op, cme_flags_t cur);
    cme_flags_t r;
    r = cur;
    case (op)
      OP_INVAL: r = '0;
      OP_PUSH:  if (cur.valid && cur.dirty) r.dirty = 1'b0;
      OP_CLEAR: r = '0;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cme_tag_store.sv
module cme_tag_store
  import cme_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en,
  input  logic                        fill_way,
  input  logic [SET_W-1:0]            fill_set,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        fill_dirty,
  input  logic                        upd_en,
  input  logic                        upd_way,
  input  logic [SET_W-1:0]            upd_set,
  input  cme_flags_t                  upd_flags,
  input  logic [SET_W-1:0]            rd_set,
  output logic [1:0][TAG_W-1:0]       rd_tag,
  output cme_flags_t [1:0]            rd_flags
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    cme_flags_t       flg_mem [SETS];
    logic             upd_hit;
    logic             fill_hit;

    assign upd_hit  = upd_en  && (upd_way  == 1'(w));
    assign fill_hit = fill_en && (fill_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) flg_mem[s] <= '0;
      end else if (upd_hit) begin
        flg_mem[upd_set] <= upd_flags;
      end else if (fill_hit) begin
        flg_mem[fill_set] <= '{valid: 1'b1, dirty: fill_dirty};
      end
    end

    always_ff @(posedge clk) begin
      if (fill_hit) tag_mem[fill_set] <= fill_tag;
    end

    assign rd_tag[w]   = tag_mem[rd_set];
    assign rd_flags[w] = flg_mem[rd_set];
  end

endmodule

// File: rtl/cme_range_plan.sv
module cme_range_plan
  import cme_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 256,
  parameter int CNT_W      = 10,
  localparam int OFS_W     = $clog2(LINE_BYTES)
) (
  input  logic [1:0]        scope,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              full_sweep,
  output logic [CNT_W-1:0]  line_cnt
);

  localparam int HALF_BYTES = SETS * LINE_BYTES;

  logic [LEN_W:0] span;
  logic           big_range;

  always_comb begin
    span      = {1'b0, len} + (LEN_W+1)'(addr[OFS_W-1:0]) + (LEN_W+1)'(LINE_BYTES - 1);
    big_range = ({1'b0, len} >= (LEN_W+1)'(HALF_BYTES));
    full_sweep = (scope == SC_ALL) || (scope == SC_ENABLE) ||
                 ((scope == SC_RANGE) && big_range);
    if (scope == SC_LINE) line_cnt = CNT_W'(1);
    else                  line_cnt = CNT_W'(span >> OFS_W);
  end

endmodule

// File: rtl/cme_sequencer.sv
module cme_sequencer
  import cme_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int TAG_W  = 20,
  parameter int OFS_W  = 4,
  parameter int CNT_W  = 10,
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_scope,
  input  logic [1:0]             cmd_op,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic                   cmd_cache_on,
  input  logic                   cmd_wbuf_on,
  input  logic                   plan_full,
  input  logic [CNT_W-1:0]       plan_cnt,
  input  logic [1:0][TAG_W-1:0]  rd_tag,
  input  cme_flags_t [1:0]       rd_flags,
  input  logic                   wb_ack,
  output logic [SET_W-1:0]       rd_set,
  output logic                   upd_en,
  output logic                   upd_way,
  output logic [SET_W-1:0]       upd_set,
  output cme_flags_t             upd_flags,
  output logic                   wb_req,
  output logic                   wb_way,
  output logic [SET_W-1:0]       wb_set,
  output logic [TAG_W-1:0]       wb_tag,
  output logic                   busy,
  output logic                   err_busy,
  output logic                   cache_en,
  output logic                   wbuf_en,
  output logic                   srch_done,
  output logic                   srch_hit,
  output logic                   srch_way,
  output logic                   srch_dirty
);

  localparam cme_flags_t DIRTY_LINE = '{valid: 1'b1, dirty: 1'b1};

  cme_state_e          state_q, state_d;
  cme_op_e             op_q, op_d;
  logic                sweep_q, sweep_d;
  logic [SET_W-1:0]    cur_set_q, cur_set_d;
  logic                cur_way_q, cur_way_d;
  logic [LINE_W-1:0]   cur_line_q, cur_line_d;
  logic [CNT_W-1:0]    remain_q, remain_d;
  logic                en_pend_q, en_pend_d;
  logic                en_cache_q, en_cache_d;
  logic                en_wbuf_q, en_wbuf_d;
  logic                wb_req_q, wb_req_d;
  logic                wb_way_q, wb_way_d;
  logic [SET_W-1:0]    wb_set_q, wb_set_d;
  logic [TAG_W-1:0]    wb_tag_q, wb_tag_d;
  logic                cache_en_q, cache_en_d;
  logic                wbuf_en_q, wbuf_en_d;
  logic                err_q, err_d;
  logic                sdone_q, sdone_d;
  logic                shit_q, shit_d;
  logic                sway_q, sway_d;
  logic                sdirty_q, sdirty_d;

  logic [SET_W-1:0]    look_set;
  logic [TAG_W-1:0]    look_tag;
  logic                hit0, hit1, line_hit, act, pick_way, needs_wb, last_step, step;
  cme_flags_t          sel_flags;
  logic [TAG_W-1:0]    sel_tag;

  // Entry under the cursor: set/way in a sweep, address lookup otherwise.
  always_comb begin
    look_set  = sweep_q ? cur_set_q : cur_line_q[SET_W-1:0];
    look_tag  = cur_line_q[LINE_W-1:SET_W];
    hit0      = rd_flags[0].valid && (rd_tag[0] == look_tag);
    hit1      = rd_flags[1].valid && (rd_tag[1] == look_tag);
    line_hit  = (remain_q != '0) && (hit0 || hit1);
    pick_way  = sweep_q ? cur_way_q : !hit0;
    act       = sweep_q ? 1'b1 : line_hit;
    sel_flags = rd_flags[pick_way];
    sel_tag   = rd_tag[pick_way];
    needs_wb  = act && ((op_q == OP_PUSH) || (op_q == OP_CLEAR)) &&
                sel_flags.valid && sel_flags.dirty;
    last_step = sweep_q ? (cur_way_q && (cur_set_q == SET_W'(SETS - 1)))
                        : (remain_q <= CNT_W'(1));
    rd_set    = (state_q == ST_WB) ? wb_set_q : look_set;
  end

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    sweep_d    = sweep_q;
    cur_set_d  = cur_set_q;
    cur_way_d  = cur_way_q;
    cur_line_d = cur_line_q;
    remain_d   = remain_q;
    en_pend_d  = en_pend_q;
    en_cache_d = en_cache_q;
    en_wbuf_d  = en_wbuf_q;
    wb_req_d   = wb_req_q;
    wb_way_d   = wb_way_q;
    wb_set_d   = wb_set_q;
    wb_tag_d   = wb_tag_q;
    cache_en_d = cache_en_q;
    wbuf_en_d  = wbuf_en_q;
    err_d      = err_q;
    sdone_d    = 1'b0;
    shit_d     = shit_q;
    sway_d     = sway_q;
    sdirty_d   = sdirty_q;
    upd_en     = 1'b0;
    upd_way    = pick_way;
    upd_set    = look_set;
    upd_flags  = cme_next_flags(op_q, sel_flags);
    step       = 1'b0;

    if (cmd_valid && (state_q != ST_IDLE)) err_d = 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          state_d    = ST_RUN;
          op_d       = (cmd_scope == SC_ENABLE) ? OP_INVAL : cme_op_e'(cmd_op);
          sweep_d    = plan_full;
          cur_set_d  = '0;
          cur_way_d  = 1'b0;
          cur_line_d = cmd_addr[ADDR_W-1:OFS_W];
          remain_d   = plan_cnt;
          en_pend_d  = (cmd_scope == SC_ENABLE);
          en_cache_d = cmd_cache_on;
          en_wbuf_d  = cmd_wbuf_on;
        end
      end
      ST_RUN: begin
        if (needs_wb) begin
          state_d  = ST_WB;
          wb_req_d = 1'b1;
          wb_way_d = pick_way;
          wb_set_d = look_set;
          wb_tag_d = sel_tag;
        end else begin
          upd_en = act && (op_q != OP_SEARCH);
          if ((op_q == OP_SEARCH) && !sweep_q && (remain_q != '0)) begin
            sdone_d  = 1'b1;
            shit_d   = hit0 || hit1;
            sway_d   = hit1 && !hit0;
            sdirty_d = line_hit && sel_flags.dirty;
          end
          step = 1'b1;
        end
      end
      ST_WB: begin
        if (wb_ack) begin
          upd_en    = 1'b1;
          upd_way   = wb_way_q;
          upd_set   = wb_set_q;
          upd_flags = cme_next_flags(op_q, DIRTY_LINE);
          wb_req_d  = 1'b0;
          step      = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (step) begin
      if (last_step) begin
        state_d = ST_IDLE;
        if (en_pend_q) begin
          cache_en_d = en_cache_q;
          wbuf_en_d  = en_wbuf_q;
          en_pend_d  = 1'b0;
        end
      end else begin
        state_d = ST_RUN;
        if (sweep_q) begin
          cur_way_d = !cur_way_q;
          if (cur_way_q) cur_set_d = cur_set_q + SET_W'(1);
        end else begin
          cur_line_d = cur_line_q + LINE_W'(1);
          remain_d   = remain_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_SEARCH;
      sweep_q    <= 1'b0;
      cur_set_q  <= '0;
      cur_way_q  <= 1'b0;
      cur_line_q <= '0;
      remain_q   <= '0;
      en_pend_q  <= 1'b0;
      en_cache_q <= 1'b0;
      en_wbuf_q  <= 1'b0;
      wb_req_q   <= 1'b0;
      wb_way_q   <= 1'b0;
      wb_set_q   <= '0;
      wb_tag_q   <= '0;
      cache_en_q <= 1'b0;
      wbuf_en_q  <= 1'b0;
      err_q      <= 1'b0;
      sdone_q    <= 1'b0;
      shit_q     <= 1'b0;
      sway_q     <= 1'b0;
      sdirty_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      op_q       <= op_d;
      sweep_q    <= sweep_d;
      cur_set_q  <= cur_set_d;
      cur_way_q  <= cur_way_d;
      cur_line_q <= cur_line_d;
      remain_q   <= remain_d;
      en_pend_q  <= en_pend_d;
      en_cache_q <= en_cache_d;
      en_wbuf_q  <= en_wbuf_d;
      wb_req_q   <= wb_req_d;
      wb_way_q   <= wb_way_d;
      wb_set_q   <= wb_set_d;
      wb_tag_q   <= wb_tag_d;
      cache_en_q <= cache_en_d;
      wbuf_en_q  <= wbuf_en_d;
      err_q      <= err_d;
      sdone_q    <= sdone_d;
      shit_q     <= shit_d;
      sway_q     <= sway_d;
      sdirty_q   <= sdirty_d;
    end
  end

  assign wb_req     = wb_req_q;
  assign wb_way     = wb_way_q;
  assign wb_set     = wb_set_q;
  assign wb_tag     = wb_tag_q;
  assign busy       = (state_q != ST_IDLE);
  assign err_busy   = err_q;
  assign cache_en   = cache_en_q;
  assign wbuf_en    = wbuf_en_q;
  assign srch_done  = sdone_q;
  assign srch_hit   = shit_q;
  assign srch_way   = sway_q;
  assign srch_dirty = sdirty_q;

endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import cme_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 256,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int SET_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFS_W - SET_W,
  localparam int CNT_W     = SET_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_scope,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_cache_on,
  input  logic              cmd_wbuf_on,
  input  logic              fill_en,
  input  logic              fill_way,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  input  logic              wb_ack,
  output logic              wb_req,
  output logic              wb_way,
  output logic [SET_W-1:0]  wb_set,
  output logic [TAG_W-1:0]  wb_tag,
  output logic              busy,
  output logic              err_busy,
  output logic              cache_en,
  output logic              wbuf_en,
  output logic              srch_done,
  output logic              srch_hit,
  output logic              srch_way,
  output logic              srch_dirty
);

  logic                  plan_full;
  logic [CNT_W-1:0]      plan_cnt;
  logic [SET_W-1:0]      rd_set;
  logic [1:0][TAG_W-1:0] rd_tag;
  cme_flags_t [1:0]      rd_flags;
  logic                  upd_en;
  logic                  upd_way;
  logic [SET_W-1:0]      upd_set;
  cme_flags_t            upd_flags;
  logic                  fill_go;

  assign fill_go = fill_en && !busy;

  cme_range_plan #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES),
    .SETS(SETS), .CNT_W(CNT_W)
  ) u_plan (
    .scope      (cmd_scope),
    .addr       (cmd_addr),
    .len        (cmd_len),
    .full_sweep (plan_full),
    .line_cnt   (plan_cnt)
  );

  cme_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_go),
    .fill_way   (fill_way),
    .fill_set   (fill_addr[OFS_W+SET_W-1:OFS_W]),
    .fill_tag   (fill_addr[ADDR_W-1:OFS_W+SET_W]),
    .fill_dirty (fill_dirty),
    .upd_en     (upd_en),
    .upd_way    (upd_way),
    .upd_set    (upd_set),
    .upd_flags  (upd_flags),
    .rd_set     (rd_set),
    .rd_tag     (rd_tag),
    .rd_flags   (rd_flags)
  );

  cme_sequencer #(
    .ADDR_W(ADDR_W), .SETS(SETS), .TAG_W(TAG_W), .OFS_W(OFS_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_scope    (cmd_scope),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_cache_on (cmd_cache_on),
    .cmd_wbuf_on  (cmd_wbuf_on),
    .plan_full    (plan_full),
    .plan_cnt     (plan_cnt),
    .rd_tag       (rd_tag),
    .rd_flags     (rd_flags),
    .wb_ack       (wb_ack),
    .rd_set       (rd_set),
    .upd_en       (upd_en),
    .upd_way      (upd_way),
    .upd_set      (upd_set),
    .upd_flags    (upd_flags),
    .wb_req       (wb_req),
    .wb_way       (wb_way),
    .wb_set       (wb_set),
    .wb_tag       (wb_tag),
    .busy         (busy),
    .err_busy     (err_busy),
    .cache_en     (cache_en),
    .wbuf_en      (wbuf_en),
    .srch_done    (srch_done),
    .srch_hit     (srch_hit),
    .srch_way     (srch_way),
    .srch_dirty   (srch_dirty)
  );

endmodule

// File: rtl/cache_maint_chk.sv
module cache_maint_chk #(
  parameter int SET_W = 8,
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             wb_ack,
  input logic             wb_req,
  input logic             wb_way,
  input logic [SET_W-1:0] wb_set,
  input logic [TAG_W-1:0] wb_tag,
  input logic             busy,
  input logic             err_busy,
  input logic             cache_en,
  input logic             wbuf_en,
  input logic             srch_done,
  input logic             srch_hit,
  input logic             srch_dirty
);

  // R7: an unanswered request keeps its identity
  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_way) && $stable(wb_set) && $stable(wb_tag));

  // R7: requests only come from a running command
  p_wb_in_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> busy);

  // R11: a command during busy raises the error flag
  p_busy_cmd_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> err_busy);

  // R11: error flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |=> err_busy);

  // R10: enable outputs change only as a command completes
  p_cache_en_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cache_en) |-> !busy && $past(busy));

  p_wbuf_en_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wbuf_en) |-> !busy && $past(busy));

  // R6: a dirty report implies a hit
  p_srch_dirty_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done && srch_dirty |-> srch_hit);

endmodule

bind cache_maint_engine cache_maint_chk #(.SET_W(SET_W), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .wb_ack     (wb_ack),
  .wb_req     (wb_req),
  .wb_way     (wb_way),
  .wb_set     (wb_set),
  .wb_tag     (wb_tag),
  .busy       (busy),
  .err_busy   (err_busy),
  .cache_en   (cache_en),
  .wbuf_en    (wbuf_en),
  .srch_done  (srch_done),
  .srch_hit   (srch_hit),
  .srch_dirty (srch_dirty)
);

// File: tb/cache_maint_engine_test.sv
`timescale 1ns/1ps
module cache_maint_engine_test;

  localparam int IW = 29;  // {way, set[7:0], tag[19:0]}

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_scope;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic        cmd_cache_on;
  logic        cmd_wbuf_on;
  logic        fill_en;
  logic        fill_way;
  logic [31:0] fill_addr;
  logic        fill_dirty;
  logic        wb_ack;
  logic        wb_req;
  logic        wb_way;
  logic [7:0]  wb_set;
  logic [19:0] wb_tag;
  logic        busy;
  logic        err_busy;
  logic        cache_en;
  logic        wbuf_en;
  logic        srch_done;
  logic        srch_hit;
  logic        srch_way;
  logic        srch_dirty;

  int n_chk;
  int n_fail;
  bit finished;
  logic [IW-1:0] exp_q[$];

  cache_maint_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_scope(cmd_scope),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_cache_on(cmd_cache_on), .cmd_wbuf_on(cmd_wbuf_on),
    .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr),
    .fill_dirty(fill_dirty), .wb_ack(wb_ack), .wb_req(wb_req),
    .wb_way(wb_way), .wb_set(wb_set), .wb_tag(wb_tag), .busy(busy),
    .err_busy(err_busy), .cache_en(cache_en), .wbuf_en(wbuf_en),
    .srch_done(srch_done), .srch_hit(srch_hit), .srch_way(srch_way),
    .srch_dirty(srch_dirty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] item(input logic w, input logic [31:0] a);
    return {w, a[11:4], a[31:12]};
  endfunction

  // Scoreboard monitor: compares each write-back request, then acknowledges it.
  initial begin
    wb_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (wb_req === 1'b1 && !wb_ack) begin
        logic [IW-1:0] got;
        got = {wb_way, wb_set, wb_tag};
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write-back", 64'(got), 64'(0));
        else begin
          logic [IW-1:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R8 write-back item/order", 64'(got), 64'(e));
        end
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(wb_req === 1'b1 && {wb_way, wb_set, wb_tag} == got, "R7 request held until ack",
              64'({wb_req, wb_way, wb_set, wb_tag}), 64'({1'b1, got}));
        end
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
      end
    end
  end

  task automatic do_fill(input logic w, input logic [31:0] a, input logic d);
    @(negedge clk);
    fill_en = 1'b1; fill_way = w; fill_addr = a; fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] sc, input logic [1:0] op, input logic [31:0] a,
                        input logic [15:0] l, input logic con, input logic won, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_scope = sc; cmd_op = op; cmd_addr = a; cmd_len = l;
    cmd_cache_on = con; cmd_wbuf_on = won;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (busy === 1'b1 && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic search(input logic [31:0] a, input logic eh, input logic ew, input logic ed, input string req);
    int c;
    do_cmd(2'd0, 2'd0, a, 16'd0, 1'b0, 1'b0, c);
    chk(srch_done === 1'b1, req, 64'(srch_done), 64'(1));
    chk(srch_hit === eh, req, 64'(srch_hit), 64'(eh));
    if (eh) begin
      chk(srch_way === ew, req, 64'(srch_way), 64'(ew));
      chk(srch_dirty === ed, req, 64'(srch_dirty), 64'(ed));
    end
  endtask

  localparam logic [31:0] A_ADR = 32'h0001_2050;
  localparam logic [31:0] B_ADR = 32'h0003_4050;
  localparam logic [31:0] D_ADR = 32'h0007_8090;
  localparam logic [31:0] E_ADR = 32'h0009_A200;
  localparam logic [31:0] F_ADR = 32'h000F_0300;
  localparam logic [31:0] G_ADR = 32'h0011_1300;
  localparam logic [31:0] H_ADR = 32'h000B_C030;
  localparam logic [31:0] I_ADR = 32'h000D_E400;
  localparam logic [31:0] J_ADR = 32'h0006_0700;
  localparam logic [31:0] K_ADR = 32'h0008_00F0;
  localparam logic [31:0] L_ADR = 32'h0000_1230;

  initial begin
    int c;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_scope = '0; cmd_op = '0; cmd_addr = '0;
    cmd_len = '0; cmd_cache_on = 1'b0; cmd_wbuf_on = 1'b0;
    fill_en = 1'b0; fill_way = 1'b0; fill_addr = '0; fill_dirty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R11 flag clear, R10 enables off)
    chk(busy === 1'b0 && wb_req === 1'b0, "R7 reset idle", 64'({busy, wb_req}), 64'(0));
    chk(err_busy === 1'b0, "R11 reset error flag", 64'(err_busy), 64'(0));
    chk(cache_en === 1'b0 && wbuf_en === 1'b0, "R10 reset enables", 64'({cache_en, wbuf_en}), 64'(0));

    // Same set in both ways, unaligned lookups (R1, R5, R6, R12)
    do_fill(1'b0, A_ADR, 1'b1);
    do_fill(1'b1, B_ADR, 1'b0);
    search(A_ADR + 32'd7, 1'b1, 1'b0, 1'b1, "R1 unaligned lookup way0");
    search(B_ADR + 32'd15, 1'b1, 1'b1, 1'b0, "R5 lookup finds way1");
    search(32'h0005_6050, 1'b0, 1'b0, 1'b0, "R6 search miss");

    // Push (R3)
    exp_q.push_back(item(1'b0, A_ADR));
    do_cmd(2'd0, 2'd2, A_ADR + 32'd3, 16'd0, 1'b0, 1'b0, c);
    search(A_ADR, 1'b1, 1'b0, 1'b0, "R3 pushed line valid and clean");
    do_cmd(2'd0, 2'd2, B_ADR, 16'd0, 1'b0, 1'b0, c);
    search(B_ADR, 1'b1, 1'b1, 1'b0, "R3 clean line untouched by push");

    // Clear (R4)
    do_fill(1'b0, D_ADR, 1'b1);
    exp_q.push_back(item(1'b0, D_ADR));
    do_cmd(2'd0, 2'd3, D_ADR, 16'd0, 1'b0, 1'b0, c);
    search(D_ADR, 1'b0, 1'b0, 1'b0, "R4 dirty line cleared");
    do_cmd(2'd0, 2'd3, B_ADR, 16'd0, 1'b0, 1'b0, c);
    search(B_ADR, 1'b0, 1'b0, 1'b0, "R4 clean line invalidated");
    search(A_ADR, 1'b1, 1'b0, 1'b0, "R4 other way untouched");

    // Invalidate dirty line, no write-back (R2)
    do_fill(1'b1, E_ADR, 1'b1);
    do_cmd(2'd0, 2'd1, E_ADR, 16'd0, 1'b0, 1'b0, c);
    search(E_ADR, 1'b0, 1'b0, 1'b0, "R2 invalidated");
    chk(exp_q.size() == 0, "R2 no write-back pending", 64'(exp_q.size()), 64'(0));

    // Line miss changes nothing (R5)
    do_fill(1'b0, F_ADR, 1'b1);
    do_cmd(2'd0, 2'd3, G_ADR, 16'd0, 1'b0, 1'b0, c);
    search(F_ADR, 1'b1, 1'b0, 1'b1, "R5 miss leaves set alone");

    // Push-all order (R8)
    do_fill(1'b1, H_ADR, 1'b1);
    do_fill(1'b0, I_ADR, 1'b1);
    exp_q.push_back(item(1'b1, H_ADR));
    exp_q.push_back(item(1'b0, F_ADR));
    exp_q.push_back(item(1'b0, I_ADR));
    do_cmd(2'd1, 2'd2, 32'h0, 16'd0, 1'b0, 1'b0, c);
    chk(exp_q.size() == 0, "R8 all sweep write-backs seen", 64'(exp_q.size()), 64'(0));
    search(H_ADR, 1'b1, 1'b1, 1'b0, "R8 swept line valid clean");

    // Sweep length (R8)
    do_cmd(2'd1, 2'd1, 32'h0, 16'd0, 1'b0, 1'b0, c);
    chk(c == 512, "R8 sweep busy cycles", 64'(c), 64'(512));
    search(A_ADR, 1'b0, 1'b0, 1'b0, "R8 invalidate-all reached set");
    search(I_ADR, 1'b0, 1'b0, 1'b0, "R8 invalidate-all reached way0");

    // Ranged push (R9)
    for (int k = 0; k < 4; k++) do_fill(1'b0, 32'h0004_0100 + 32'(16 * k), 1'b1);
    for (int k = 0; k < 3; k++) exp_q.push_back(item(1'b0, 32'h0004_0100 + 32'(16 * k)));
    do_cmd(2'd2, 2'd2, 32'h0004_0108, 16'h0020, 1'b0, 1'b0, c);
    chk(exp_q.size() == 0, "R9 range write-backs", 64'(exp_q.size()), 64'(0));
    search(32'h0004_0130, 1'b1, 1'b0, 1'b1, "R9 line past range untouched");
    search(32'h0004_0120, 1'b1, 1'b0, 1'b0, "R9 last byte line pushed");

    // Length 4095 stays a line walk (R9)
    do_fill(1'b0, K_ADR, 1'b1);
    exp_q.push_back(item(1'b0, 32'h0004_0130));
    do_cmd(2'd2, 2'd2, 32'h0004_0100, 16'd4095, 1'b0, 1'b0, c);
    chk(exp_q.size() == 0, "R9 4095 range write-backs", 64'(exp_q.size()), 64'(0));
    search(K_ADR, 1'b1, 1'b0, 1'b1, "R9 line outside 4095 range still dirty");

    // Length 4096 becomes a sweep (R9)
    do_fill(1'b1, J_ADR, 1'b1);
    exp_q.push_back(item(1'b0, K_ADR));
    exp_q.push_back(item(1'b1, J_ADR));
    do_cmd(2'd2, 2'd3, 32'h0004_0100, 16'd4096, 1'b0, 1'b0, c);
    chk(exp_q.size() == 0, "R9 full clear write-backs", 64'(exp_q.size()), 64'(0));
    search(32'h0004_0110, 1'b0, 1'b0, 1'b0, "R9 full clear invalidated");

    // Enable: invalidate first, enables at end (R10)
    do_fill(1'b0, L_ADR, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_scope = 2'd3; cmd_op = 2'd2; cmd_addr = '0; cmd_len = '0;
    cmd_cache_on = 1'b1; cmd_wbuf_on = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1 && cache_en === 1'b0, "R10 enable waits for sweep",
        64'({busy, cache_en}), 64'(2));
    c = 0;
    while (busy === 1'b1 && c < 20000) begin c++; @(negedge clk); end
    chk(c == 512, "R10 enable sweep length", 64'(c), 64'(512));
    chk(cache_en === 1'b1 && wbuf_en === 1'b1, "R10 enables set", 64'({cache_en, wbuf_en}), 64'(3));
    search(L_ADR, 1'b0, 1'b0, 1'b0, "R10 dirty line dropped without write-back");
    chk(err_busy === 1'b0, "R11 no error so far", 64'(err_busy), 64'(0));

    // Busy: command and fill ignored (R11, R12)
    do_fill(1'b0, F_ADR, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_scope = 2'd1; cmd_op = 2'd1; cmd_addr = '0; cmd_len = '0;
    cmd_cache_on = 1'b0; cmd_wbuf_on = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    fill_en = 1'b1; fill_way = 1'b0; fill_addr = 32'h0000_2000; fill_dirty = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
    cmd_valid = 1'b1; cmd_scope = 2'd3; cmd_op = 2'd0; cmd_cache_on = 1'b0; cmd_wbuf_on = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    c = 0;
    while (busy === 1'b1 && c < 20000) begin c++; @(negedge clk); end
    chk(err_busy === 1'b1, "R11 error flag set", 64'(err_busy), 64'(1));
    chk(cache_en === 1'b1 && wbuf_en === 1'b1, "R11 ignored enable command",
        64'({cache_en, wbuf_en}), 64'(3));
    search(32'h0000_2000, 1'b0, 1'b0, 1'b0, "R12 fill during busy ignored");
    search(F_ADR, 1'b0, 1'b0, 1'b0, "R12 fill before sweep then invalidated");
    do_fill(1'b1, 32'h0000_2000, 1'b0);
    search(32'h0000_2000, 1'b1, 1'b1, 1'b0, "R12 fill when idle");
    chk(err_busy === 1'b1, "R11 error flag sticky", 64'(err_busy), 64'(1));
    chk(exp_q.size() == 0, "R3 no leftover expected write-backs", 64'(exp_q.size()), 64'(0));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule